// File: doc/BRIEF.md
# PLL Synthesizer Serial Programming Sequencer

This block sits on the host side of a frequency synthesizer. The synthesizer is configured over three wires: a serial clock, a data line and a load strobe. A separate chip-enable output takes the synthesizer out of power-down. A start request snapshots three parallel 24-bit configuration words and sends them in the power-up order the synthesizer needs: reference divider first, then control, then the N divider. Each word goes out MSB first. The strobe is pulsed after each word to commit it to the target latch.

After the first bring-up, a single-word update can rewrite one latch. The update carries a 2-bit latch select and a 22-bit payload. The select is placed in the two least significant bits of the word, because that is where the synthesizer decodes the destination.

Once a write completes, the block polls the lock-detect input. It reports lock only after that input has stayed high for a programmable run of consecutive samples. The serial clock comes from the system clock through a divider derived from two parameters, so it never exceeds the synthesizer's 20 MHz limit.

Top module: `synth_prog_seq`

## Requirements
- R1: Every word is 24 bits, shifted out MSB first, with exactly 24 rising serial-clock edges per word. The strobe stays low during those edges, and one strobe pulse follows each word.
- R2: The data line changes only while the serial clock is low. The receiver samples it on the rising edge.
- R3: The strobe goes high after the 24th falling edge and stays high for exactly one serial period (2*HALF system clocks). The serial clock stays low while the strobe is high. The strobe is low for at least one serial period before the next word's first rising edge.
- R4: A start request sends the reference word, then the control word, then the N word. The values are those present on the inputs in the cycle the request is accepted; later input changes have no effect on that sequence.
- R5: Each serial-clock half period lasts HALF = ceil(SYS_HZ / (2*SCLK_MAX_HZ)) system clocks. With the defaults this is 7 cycles, so the serial clock is at or below 20 MHz.
- R6: Chip-enable is low after reset. It goes high on the first accepted request, at least one serial period before the first rising edge of the serial clock, and it then stays high. While chip-enable is low, the serial clock and the strobe stay low.
- R7: A single-word update sends {upd_data[21:0], upd_sel[1:0]}. The select occupies bits 1:0, the latch address field the synthesizer decodes, and any value 0 to 3 is passed through unchanged.
- R8: busy is high from the cycle after a request is accepted until the write completes. A start or update asserted while busy is dropped, not queued. When start and update are asserted together, start wins.
- R9: done is a one-cycle pulse. It rises 2 + 52*HALF system clocks per word after the first word is issued, plus 2*HALF lead cycles when chip-enable was low at acceptance.
- R10: Polling begins with done. locked rises after LOCK_N consecutive high lock-detect samples, which is LOCK_N cycles after done when the input is held high. A low sample restarts the count and drops locked.
- R11: locked drops in the cycle after any request is accepted and stays low while busy.
- R12: While reset is held and right after it, sclk, sdata, le, ce, busy, done and locked are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request the three-word power-up sequence |
| ref_word | input | 24 | Reference divider word, sent first |
| ctl_word | input | 24 | Control word, sent second |
| ndiv_word | input | 24 | N divider word, sent third |
| upd_req | input | 1 | Request a single-word write |
| upd_sel | input | 2 | Latch select, placed in word bits 1:0 |
| upd_data | input | 22 | Payload for word bits 23:2 |
| lock_det | input | 1 | Lock-detect level from the synthesizer (synchronous) |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data, MSB first |
| le | output | 1 | Load strobe |
| ce | output | 1 | Synthesizer chip-enable |
| busy | output | 1 | A write is in progress; requests are dropped |
| done | output | 1 | One-cycle completion pulse |
| locked | output | 1 | Qualified lock status |

## Verification
Assertions check the serial timing on every cycle:
- the data line never moves while the serial clock is high;
- the strobe and the serial clock are never high together;
- every high half period is exactly HALF cycles long;
- nothing toggles before chip-enable is raised, and chip-enable never falls;
- done lasts one cycle;
- locked is never set while busy, and it only rises after a high lock-detect sample.

Only the bench scenarios can show the rest:
- the word contents and their R, control, N order;
- that a sequence uses its snapshot rather than the live inputs;
- that requests made while busy are dropped;
- where the latch select lands in the word;
- the exact done and lock latencies.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int WORD_W = 24;
    localparam int SEL_W  = 2;
    localparam int N_SEQ  = 3;

    typedef logic [WORD_W-1:0] cfg_word_t;

    typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_LOAD, SH_GAP} sh_state_t;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_SEND, SQ_WAIT} sq_state_t;

    typedef struct packed {
        logic sclk;
        logic le;
        logic sdata;
    } ser_pins_t;

    // System clocks per serial half period, rounded up so the limit holds.
    function automatic int half_period(input longint sys_hz, input longint max_hz);
        longint q;
        q = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (q < 1) ? 1 : int'(q);
    endfunction

endpackage

// File: rtl/sclk_tick.sv
module sclk_tick #(
    parameter int HALF = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF) + 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/prog_shifter.sv
module prog_shifter
    import synth_prog_pkg::*;
#(
    parameter int HALF = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  cfg_word_t word,
    output ser_pins_t pins,
    output logic      fin
);
    localparam int BW = $clog2(WORD_W);

    sh_state_t     state;
    cfg_word_t     sr;
    logic [BW-1:0] bitcnt;
    logic          sclk_q, le_q, sub, fin_q, tick;

    sclk_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state != SH_IDLE),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            sr     <= '0;
            bitcnt <= '0;
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
            sub    <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            unique case (state)
                SH_IDLE: if (go) begin
                    sr     <= word;
                    bitcnt <= '0;
                    state  <= SH_BITS;
                end
                SH_BITS: if (tick) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bitcnt == BW'(WORD_W - 1)) begin
                            state <= SH_LOAD;
                            le_q  <= 1'b1;
                        end else begin
                            sr     <= {sr[WORD_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                SH_LOAD: if (tick) begin
                    sub <= ~sub;
                    if (sub) begin
                        le_q  <= 1'b0;
                        state <= SH_GAP;
                    end
                end
                SH_GAP: if (tick) begin
                    sub <= ~sub;
                    if (sub) begin
                        state <= SH_IDLE;
                        fin_q <= 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.sclk  = sclk_q;
        pins.le    = le_q;
        pins.sdata = (state == SH_BITS) ? sr[WORD_W-1] : 1'b0;
    end

    assign fin = fin_q;
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
    parameter int LOCK_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm,
    input  logic lock_det,
    output logic locked
);
    localparam int CW = $clog2(LOCK_N + 1);

    logic          poll;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            poll <= 1'b0;
            cnt  <= '0;
        end else begin
            if (arm) poll <= 1'b1;
            if (poll) begin
                if (!lock_det)                cnt <= '0;
                else if (cnt != CW'(LOCK_N))  cnt <= cnt + 1'b1;
            end
        end
    end

    assign locked = poll && (cnt == CW'(LOCK_N));
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
    import synth_prog_pkg::*;
#(
    parameter longint SYS_HZ      = 250_000_000,
    parameter longint SCLK_MAX_HZ = 20_000_000,
    parameter int     LOCK_N      = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [WORD_W-1:0]       ref_word,
    input  logic [WORD_W-1:0]       ctl_word,
    input  logic [WORD_W-1:0]       ndiv_word,
    input  logic                    upd_req,
    input  logic [SEL_W-1:0]        upd_sel,
    input  logic [WORD_W-SEL_W-1:0] upd_data,
    input  logic                    lock_det,
    output logic                    sclk,
    output logic                    sdata,
    output logic                    le,
    output logic                    ce,
    output logic                    busy,
    output logic                    done,
    output logic                    locked
);
    localparam int HALF = half_period(SYS_HZ, SCLK_MAX_HZ);
    localparam int LW   = $clog2(2 * HALF) + 1;

    sq_state_t     state;
    cfg_word_t     words [N_SEQ];
    logic [1:0]    idx, last;
    logic [LW-1:0] lead_cnt;
    logic          ce_q, done_q, fin, go, arm;
    logic          accept_seq, accept_one;
    ser_pins_t     pins;

    assign accept_seq = (state == SQ_IDLE) && start;
    assign accept_one = (state == SQ_IDLE) && upd_req && !start;
    assign go         = (state == SQ_SEND);
    assign arm        = (state == SQ_WAIT) && fin && (idx == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            last     <= '0;
            lead_cnt <= '0;
            ce_q     <= 1'b0;
            done_q   <= 1'b0;
            for (int i = 0; i < N_SEQ; i++) words[i] <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                SQ_IDLE: if (accept_seq || accept_one) begin
                    ce_q     <= 1'b1;
                    idx      <= '0;
                    lead_cnt <= '0;
                    state    <= ce_q ? SQ_SEND : SQ_LEAD;
                    if (accept_seq) begin
                        words[0] <= ref_word;
                        words[1] <= ctl_word;
                        words[2] <= ndiv_word;
                        last     <= 2'(N_SEQ - 1);
                    end else begin
                        words[0] <= {upd_data, upd_sel};
                        last     <= '0;
                    end
                end
                SQ_LEAD: begin
                    if (lead_cnt == LW'(2 * HALF - 1)) state <= SQ_SEND;
                    else                               lead_cnt <= lead_cnt + 1'b1;
                end
                SQ_SEND: state <= SQ_WAIT;
                SQ_WAIT: if (fin) begin
                    if (idx == last) begin
                        state  <= SQ_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= SQ_SEND;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    prog_shifter #(.HALF(HALF)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .word (words[idx]),
        .pins (pins),
        .fin  (fin)
    );

    lock_qualifier #(.LOCK_N(LOCK_N)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept_seq || accept_one),
        .arm      (arm),
        .lock_det (lock_det),
        .locked   (locked)
    );

    assign sclk  = pins.sclk;
    assign sdata = pins.sdata;
    assign le    = pins.le;
    assign ce    = ce_q;
    assign busy  = (state != SQ_IDLE);
    assign done  = done_q;
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk #(
    parameter int HALF = 7
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic sdata,
    input logic le,
    input logic ce,
    input logic busy,
    input logic done,
    input logic locked,
    input logic lock_det
);
    localparam int RW = $clog2(HALF + 2) + 1;

    logic          sclk_prev;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            run       <= '0;
        end else begin
            sclk_prev <= sclk;
            if (sclk != sclk_prev) run <= RW'(1);
            else if (run != '1)    run <= run + 1'b1;
        end
    end

    p_data_low_clk_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> !sclk);

    p_strobe_no_clk_r3: assert property (@(posedge clk) disable iff (rst)
        le |-> !sclk);

    p_high_width_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk_prev && !sclk) |-> (run == RW'(HALF)));

    p_low_width_r5: assert property (@(posedge clk) disable iff (rst)
        (!sclk_prev && sclk) |-> (run >= RW'(HALF)));

    p_ce_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !ce |-> (!sclk && !le));

    p_ce_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ce |=> ce);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_locked_idle_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !locked);

    p_lock_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(lock_det));
endmodule

bind synth_prog_seq synth_prog_chk #(.HALF(HALF)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .sdata    (sdata),
    .le       (le),
    .ce       (ce),
    .busy     (busy),
    .done     (done),
    .locked   (locked),
    .lock_det (lock_det)
);

// File: tb/tb_synth_prog_seq.sv
module tb_synth_prog_seq;
    localparam int H  = (250_000_000 + 2 * 20_000_000 - 1) / (2 * 20_000_000);
    localparam int LN = 4;
    localparam int WP = 52 * H + 2;

    logic        clk = 1'b0, rst = 1'b1;
    logic        start = 1'b0, upd_req = 1'b0, lock_det = 1'b0;
    logic [23:0] ref_word = '0, ctl_word = '0, ndiv_word = '0;
    logic [1:0]  upd_sel = '0;
    logic [21:0] upd_data = '0;
    logic        sclk, sdata, le, ce, busy, done, locked;

    always #2 clk = ~clk;

    synth_prog_seq #(.SYS_HZ(250_000_000), .SCLK_MAX_HZ(20_000_000), .LOCK_N(LN)) dut (
        .clk(clk), .rst(rst), .start(start), .ref_word(ref_word), .ctl_word(ctl_word),
        .ndiv_word(ndiv_word), .upd_req(upd_req), .upd_sel(upd_sel), .upd_data(upd_data),
        .lock_det(lock_det), .sclk(sclk), .sdata(sdata), .le(le), .ce(ce), .busy(busy),
        .done(done), .locked(locked));

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Receiving device model: samples on rising serial clock, commits on strobe.
    logic [23:0] rx_sh = '0;
    int          rx_bits = 0, ncap = 0;
    logic [23:0] cap [0:63];
    int          cap_bits [0:63];
    logic        cap_ce [0:63];

    always @(posedge sclk) if (!le) begin
        rx_sh = {rx_sh[22:0], sdata};
        rx_bits++;
    end

    always @(posedge le) begin
        if (ncap < 64) begin
            cap[ncap] = rx_sh; cap_bits[ncap] = rx_bits; cap_ce[ncap] = ce;
        end
        ncap++;
        rx_bits = 0;
    end

    // Pin timing monitor, sampled between edges.
    logic s_prev = 0, l_prev = 0, sd_prev = 0, first_rise = 1, gap_arm = 0;
    int s_run = 0, l_run = 0, hi_min = 9999, hi_max = 0, lo_min = 9999;
    int le_min = 9999, le_max = 0, gap_cnt = 0, gap_min = 9999;
    int ce_cnt = 0, ce_lead = -1, d_run = 0, d_max = 0, d_pulses = 0;
    int sd_bad = 0, le_clk_bad = 0;

    always @(negedge clk) if (!rst) begin
        if (sclk && s_prev && sdata != sd_prev) sd_bad++;
        if (le && sclk) le_clk_bad++;
        if (ce) ce_cnt++;
        if (le != l_prev) begin
            if (l_prev) begin
                if (l_run < le_min) le_min = l_run;
                if (l_run > le_max) le_max = l_run;
                gap_arm = 1; gap_cnt = 0;
            end
            l_run = 1;
        end else l_run++;
        if (sclk != s_prev) begin
            if (s_prev) begin
                if (s_run < hi_min) hi_min = s_run;
                if (s_run > hi_max) hi_max = s_run;
            end else begin
                if (s_run < lo_min) lo_min = s_run;
                if (gap_arm) begin
                    if (gap_cnt < gap_min) gap_min = gap_cnt;
                    gap_arm = 0;
                end
                if (first_rise) begin ce_lead = ce_cnt; first_rise = 0; end
            end
            s_run = 1;
        end else s_run++;
        if (gap_arm && !le) gap_cnt++;
        if (done) begin d_run++; if (d_run == 1) d_pulses++; end else d_run = 0;
        if (d_run > d_max) d_max = d_run;
        s_prev = sclk; l_prev = le; sd_prev = sdata;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Counts negedges from the request (negedge 0) until done is seen.
    task automatic wait_done(output int n, input bit disturb);
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1) begin start = 0; upd_req = 0; end
            if (disturb && n == 20) begin upd_req = 1; upd_sel = 2'd3; upd_data = 22'h3FFFFF; end
            if (disturb && n == 21) begin upd_req = 0; chk(busy == 1, "R8 busy during sequence", busy, 1); end
            if (disturb && n == 30) begin ref_word = '0; ctl_word = '0; ndiv_word = '0; end
            if (disturb && n == 40) start = 1;
            if (disturb && n == 41) start = 0;
        end while (!done && n < 20000);
    endtask

    initial begin
        int n, base, lat, dp;
        logic [23:0] er, ec, en;

        repeat (4) @(negedge clk);
        chk({sclk, sdata, le, ce, busy, done, locked} == 0, "R12 in reset",
            {sclk, sdata, le, ce, busy, done, locked}, 0);
        rst = 0;
        @(negedge clk);
        chk({sclk, sdata, le, ce, busy, done, locked} == 0, "R12 after reset",
            {sclk, sdata, le, ce, busy, done, locked}, 0);
        lock_det = 1;

        // Full power-up sequences over several word patterns.
        for (int k = 0; k < 4; k++) begin
            er = (24'hC00001 << k) ^ (24'h010203 * k);
            ec = ~er ^ 24'h5A5A5A;
            en = 24'hFFFFFF - 24'h111111 * k;
            ref_word = er; ctl_word = ec; ndiv_word = en;
            base = ncap; dp = d_pulses;
            start = 1;
            wait_done(n, k == 1);
            chk(n == ((k == 0) ? 2 * H + 3 * WP + 1 : 3 * WP + 1), "R9 sequence latency", n,
                (k == 0) ? 2 * H + 3 * WP + 1 : 3 * WP + 1);
            chk(locked == 0 && busy == 0, "R11 locked low at done", locked, 0);
            chk(ncap - base == 3, "R1 one strobe per word", ncap - base, 3);
            chk(cap[base] == er, "R4 first word is reference", cap[base], er);
            chk(cap[base + 1] == ec, "R4 second word is control", cap[base + 1], ec);
            chk(cap[base + 2] == en, "R4 third word is N", cap[base + 2], en);
            for (int j = 0; j < 3; j++) begin
                chk(cap_bits[base + j] == 24, "R1 rising edges per word", cap_bits[base + j], 24);
                chk(cap_ce[base + j] == 1, "R6 ce high while writing", cap_ce[base + j], 1);
            end
            lat = 0;
            for (int j = 1; j <= 2 * LN + 2; j++) begin
                @(negedge clk);
                if (locked && lat == 0) lat = j;
                lock_det = !(k == 2 && j == 3);
            end
            lock_det = 1;
            chk(lat == ((k == 2) ? 2 * LN : LN), "R10 lock qualification delay", lat,
                (k == 2) ? 2 * LN : LN);
            chk(ncap - base == 3 && d_pulses - dp == 1, "R8 dropped requests stay dropped",
                ncap - base, 3);
            if (k == 3) begin
                lock_det = 0;
                @(negedge clk);
                chk(locked == 0, "R10 low sample drops locked", locked, 0);
                lock_det = 1;
                repeat (LN + 1) @(negedge clk);
                chk(locked == 1, "R10 relock after restart", locked, 1);
            end
        end

        // Single-word updates over every latch select.
        for (int s = 0; s < 4; s++) begin
            logic [21:0] pd;
            pd = 22'h2AAAAA ^ (22'h0F0F0F * s);
            upd_sel = 2'(s); upd_data = pd;
            base = ncap;
            chk(locked == 1, "R10 locked before update", locked, 1);
            upd_req = 1;
            @(negedge clk);
            upd_req = 0;
            chk(busy == 1 && locked == 0, "R11 locked clears on accept", {busy, locked}, 2);
            wait_done(n, 0);
            chk(n + 1 == WP + 1, "R9 single write latency", n + 1, WP + 1);
            chk(ncap - base == 1, "R7 one word per update", ncap - base, 1);
            chk(cap[base] == {pd, 2'(s)}, "R7 select in bits 1:0", cap[base], {pd, 2'(s)});
            repeat (LN + 1) @(negedge clk);
        end

        // Start and update together: start wins.
        er = 24'h123456; ec = 24'h789ABC; en = 24'hDEF012;
        ref_word = er; ctl_word = ec; ndiv_word = en;
        upd_sel = 2'd1; upd_data = 22'h155555;
        base = ncap;
        start = 1; upd_req = 1;
        wait_done(n, 0);
        chk(ncap - base == 3 && cap[base] == er && cap[base + 2] == en, "R8 start has priority",
            cap[base], er);
        repeat (200) @(negedge clk);
        chk(ncap - base == 3, "R8 no queued update", ncap - base, 3);

        chk(hi_min == H && hi_max == H, "R5 high half period", hi_max, H);
        chk(lo_min == H, "R5 low half period", lo_min, H);
        chk(le_min == 2 * H && le_max == 2 * H, "R3 strobe width", le_max, 2 * H);
        chk(gap_min >= 2 * H, "R3 strobe low before next word", gap_min, 2 * H);
        chk(le_clk_bad == 0, "R3 clock low during strobe", le_clk_bad, 0);
        chk(sd_bad == 0, "R2 data stable while clock high", sd_bad, 0);
        chk(ce_lead >= 2 * H, "R6 ce lead before first edge", ce_lead, 2 * H);
        chk(d_max == 1, "R9 done width", d_max, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule